// File: doc/BRIEF.md
# Self-Testing Asynchronous Serial Transceiver

This block sends and receives 8-bit characters over a pair of asynchronous serial lines. On the transmit side, a parallel byte is presented together with a one-cycle start request. The block then shifts the byte out as a framed serial character. It raises a ready flag once the line is free again. On the receive side, the incoming line is watched continuously. Each correctly framed character is delivered as a parallel byte, together with a one-cycle strobe.

A 2-bit rate select picks one of four parameterised clock divisions. These set the oversampling tick, and every bit lasts sixteen ticks. The transmitter has its own tick divider. That divider is held cleared while the transmitter is idle, so that bit edges stay at a fixed distance from the accepted start request.

A loopback input turns the block into a closed test loop. The receiver then listens to the transmitter's own serial output and no longer to the external input. This lets software or a test engine check both halves without external wiring.

Top module: `uart_loop_xcvr`

## Requirements
- R1: While reset is asserted, and directly after it, `txd_out` is 1, `tx_rdy` is 1 and `rx_strobe` is 0.
- R2: A frame is one start bit at 0, then the 8 data bits with bit 0 first, then one stop bit at 1. Between frames `txd_out` is 1, and this also holds in loopback.
- R3: With `rate_sel` = n, every transmitted bit lasts exactly 16·DIVn clock cycles. The defaults are DIV0..DIV3 = 1, 2, 4, 8. The start bit goes low in the cycle after the accepting clock edge.
- R4: A `tx_go` high while `tx_rdy` is high is accepted at that clock edge. `tx_rdy` is 0 from the next cycle until the stop bit ends, which is 160·DIVn cycles after acceptance, and then returns to 1.
- R5: A `tx_go` pulse while `tx_rdy` is 0 has no effect. No second frame follows, and the byte in flight is unchanged.
- R6: After a frame whose stop bit samples as 1, `rx_strobe` is high for exactly one cycle, with the received byte on `rx_byte`.
- R7: With `loop_en` = 1, the receiver takes the transmitter's serial output and ignores `rxd_in`. A byte sent is then received back unchanged, and a low `rxd_in` causes no reception.
- R8: A frame whose stop bit samples as 0 gives no strobe. The receiver waits for the line to return to 1, and then accepts the next frame normally.
- R9: A low pulse on the receive line that is shorter than half a bit is rejected as a false start and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 2 | Selects divider DIV0..DIV3 for the bit rate |
| loop_en | input | 1 | 1 routes the transmit line into the receiver |
| rxd_in | input | 1 | External serial input, asynchronous |
| tx_go | input | 1 | Request to send `tx_byte` |
| tx_byte | input | 8 | Byte to transmit, captured on acceptance |
| txd_out | output | 1 | Serial output, idles at 1 |
| tx_rdy | output | 1 | 1 when the transmitter can accept a byte |
| rx_strobe | output | 1 | One-cycle pulse when a byte has been received |
| rx_byte | output | 8 | Last received byte |

## Verification
The hardest case to reach from the ports is the receiver's recovery path. It is entered only after a stop bit that reads low, and the on-chip transmitter can never produce that. The bench therefore drives `rxd_in` bit by bit with its own timing. It sends a frame whose stop bit is held at 0 and then a clean frame, and checks that the first gives no strobe and the second is received. Rejection of a false start is reached the same way, with a quarter-bit low pulse. Busy-time requests are injected in loopback, halfway through a frame, with a different byte on `tx_byte`.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_t;

endpackage

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int unsigned DIV0 = 1,
  parameter int unsigned DIV1 = 2,
  parameter int unsigned DIV2 = 4,
  parameter int unsigned DIV3 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       clr,
  output logic       tick
);
  localparam int unsigned MAX_AB = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned MAX_CD = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int unsigned MAXD   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W  = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      2'd0:    lim = CNT_W'(DIV0 - 1);
      2'd1:    lim = CNT_W'(DIV1 - 1);
      2'd2:    lim = CNT_W'(DIV2 - 1);
      default: lim = CNT_W'(DIV3 - 1);
    endcase
  end

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q >= lim) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_loop_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              rdy
);
  localparam int unsigned SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  tx_state_t         state_q, state_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              txd_q, txd_d;

  always_comb begin
    state_d = state_q;
    sub_d   = sub_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    txd_d   = txd_q;
    case (state_q)
      TX_IDLE: begin
        txd_d = 1'b1;
        if (go) begin
          state_d = TX_START;
          shf_d   = data;
          sub_d   = '0;
          bit_d   = '0;
          txd_d   = 1'b0;
        end
      end
      TX_START: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            state_d = TX_DATA;
            sub_d   = '0;
            txd_d   = shf_q[0];
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      TX_DATA: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            shf_d = shf_q >> 1;
            if (bit_q == BIT_LAST) begin
              state_d = TX_STOP;
              txd_d   = 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
              txd_d = shf_q[1];
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            state_d = TX_IDLE;
            sub_d   = '0;
            txd_d   = 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      txd_q   <= txd_d;
    end
  end

  assign txd = txd_q;
  assign rdy = (state_q == TX_IDLE);

  // R4
  go_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rdy) |=> (!rdy && !txd));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !rdy && !tick) |=> $stable(shf_q));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_loop_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic              strobe,
  output logic [DATA_W-1:0] byte_out
);
  localparam int unsigned SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_state_t         state_q, state_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              strobe_q, strobe_d;

  always_comb begin
    state_d  = state_q;
    sub_d    = sub_q;
    bit_d    = bit_q;
    shf_d    = shf_q;
    byte_d   = byte_q;
    strobe_d = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (tick && !line) begin
          state_d = RX_START;
          sub_d   = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (sub_q == SUB_MID) begin
            sub_d   = '0;
            bit_d   = '0;
            state_d = line ? RX_IDLE : RX_DATA;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            shf_d = {line, shf_q[DATA_W-1:1]};
            if (bit_q == BIT_LAST) state_d = RX_STOP;
            else                   bit_d   = bit_q + 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            if (line) begin
              strobe_d = 1'b1;
              byte_d   = shf_q;
              state_d  = RX_IDLE;
            end else begin
              state_d = RX_WAIT_HI;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: begin
        if (tick && line) state_d = RX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      sub_q    <= '0;
      bit_q    <= '0;
      shf_q    <= '0;
      byte_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sub_q    <= sub_d;
      bit_q    <= bit_d;
      shf_q    <= shf_d;
      byte_q   <= byte_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe   = strobe_q;
  assign byte_out = byte_q;

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  // R8
  strobe_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> ($past(state_q) == RX_STOP && state_q == RX_IDLE));

endmodule

// File: rtl/uart_loop_xcvr.sv
module uart_loop_xcvr #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16,
  parameter int unsigned DIV0   = 1,
  parameter int unsigned DIV1   = 2,
  parameter int unsigned DIV2   = 4,
  parameter int unsigned DIV3   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              loop_en,
  input  logic              rxd_in,
  input  logic              tx_go,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              txd_out,
  output logic              tx_rdy,
  output logic              rx_strobe,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned N_GEN  = 2;
  localparam int unsigned GEN_TX = 0;
  localparam int unsigned GEN_RX = 1;

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic [1:0]       rxd_sync_q;
  logic             rx_line;
  logic             txd_int;
  logic [N_GEN-1:0] clr_v, tick_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rxd_sync_q <= 2'b11;
    else             rxd_sync_q <= {rxd_sync_q[0], rxd_in};
  end

  assign rx_line       = loop_en ? txd_int : rxd_sync_q[1];
  assign clr_v[GEN_TX] = tx_rdy;
  assign clr_v[GEN_RX] = 1'b0;

  for (genvar g = 0; g < N_GEN; g++) begin : g_rate
    uart_rate_gen #(
      .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) i_rate (
      .clk  (clk),
      .rst_n(core_rst_n),
      .sel  (rate_sel),
      .clr  (clr_v[g]),
      .tick (tick_v[g])
    );
  end

  uart_tx_core #(.DATA_W(DATA_W), .OSR(OSR)) i_tx (
    .clk  (clk),
    .rst_n(core_rst_n),
    .tick (tick_v[GEN_TX]),
    .go   (tx_go),
    .data (tx_byte),
    .txd  (txd_int),
    .rdy  (tx_rdy)
  );

  uart_rx_core #(.DATA_W(DATA_W), .OSR(OSR)) i_rx (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick_v[GEN_RX]),
    .line    (rx_line),
    .strobe  (rx_strobe),
    .byte_out(rx_byte)
  );

  assign txd_out = txd_int;

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    tx_rdy |-> txd_out);

  // R7
  loop_path_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    loop_en |-> (rx_line == txd_out));

endmodule

// File: tb/test_uart_loop_xcvr.sv
module test_uart_loop_xcvr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic       loop_en;
  logic       rxd_in;
  logic       tx_go;
  logic [7:0] tx_byte;
  logic       txd_out, tx_rdy, rx_strobe;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_bad = 0;
  int n_strobe = 0;
  logic [7:0] got_byte = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_loop_xcvr #(
    .DATA_W(8), .OSR(16), .DIV0(1), .DIV1(2), .DIV2(4), .DIV3(8)
  ) i_uart_loop_xcvr (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .loop_en(loop_en),
    .rxd_in(rxd_in), .tx_go(tx_go), .tx_byte(tx_byte),
    .txd_out(txd_out), .tx_rdy(tx_rdy), .rx_strobe(rx_strobe), .rx_byte(rx_byte)
  );

  always @(negedge clk) begin
    if (rx_strobe) begin
      n_strobe++;
      got_byte = rx_byte;
    end
  end

  function automatic int div_of(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rate_sel = 2'd0; loop_en = 1'b0; rxd_in = 1'b1;
    tx_go = 1'b0; tx_byte = 8'h00;
    idle(3);
    chk("R1 txd_out in reset", int'(txd_out), 1);
    chk("R1 tx_rdy in reset", int'(tx_rdy), 1);
    chk("R1 rx_strobe in reset", int'(rx_strobe), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 txd_out after reset", int'(txd_out), 1);
    chk("R1 tx_rdy after reset", int'(tx_rdy), 1);
  endtask

  task automatic t_tx_frame(input int s, input logic [7:0] b);
    int d = div_of(s);
    int bl = 16 * d;
    loop_en = 1'b0; rate_sel = 2'(s); tx_byte = b; tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
    for (int k = 0; k <= 10 * bl; k++) begin
      if (k == 0) begin
        chk("R4 tx_rdy low after accept", int'(tx_rdy), 0);
        chk("R3 start bit low at once", int'(txd_out), 0);
      end
      if (k == bl - 1) chk("R3 start bit last cycle", int'(txd_out), 0);
      if (k == bl)     chk("R3 bit0 begins on time", int'(txd_out), int'(b[0]));
      for (int i = 1; i <= 8; i++)
        if (k == bl * i + bl / 2) chk("R2 data bit, LSB first", int'(txd_out), int'(b[i-1]));
      if (k == 9 * bl + bl / 2) chk("R2 stop bit high", int'(txd_out), 1);
      if (k == 10 * bl - 1) chk("R4 tx_rdy low to end of stop", int'(tx_rdy), 0);
      if (k == 10 * bl) begin
        chk("R4 tx_rdy back after frame", int'(tx_rdy), 1);
        chk("R2 line idles high", int'(txd_out), 1);
      end
      @(negedge clk);
    end
  endtask

  task automatic drive_frame(input int s, input logic [7:0] b, input logic stop_v);
    int bl = 16 * div_of(s);
    rxd_in = 1'b0; idle(bl);
    for (int i = 0; i < 8; i++) begin rxd_in = b[i]; idle(bl); end
    rxd_in = stop_v; idle(bl);
    rxd_in = 1'b1;
  endtask

  task automatic t_rx_ext(input int s, input logic [7:0] b);
    int n0 = n_strobe;
    loop_en = 1'b0; rate_sel = 2'(s);
    drive_frame(s, b, 1'b1);
    idle(32 * div_of(s));
    chk("R6 one strobe per frame", n_strobe - n0, 1);
    chk("R6 received byte", int'(got_byte), int'(b));
  endtask

  task automatic t_frame_err(input int s);
    int n0 = n_strobe;
    loop_en = 1'b0; rate_sel = 2'(s);
    drive_frame(s, 8'h96, 1'b0);
    idle(32 * div_of(s));
    chk("R8 no strobe on low stop bit", n_strobe - n0, 0);
    drive_frame(s, 8'h69, 1'b1);
    idle(32 * div_of(s));
    chk("R8 recovers for next frame", n_strobe - n0, 1);
    chk("R8 next byte correct", int'(got_byte), 32'h69);
  endtask

  task automatic t_glitch(input int s);
    int n0 = n_strobe;
    loop_en = 1'b0; rate_sel = 2'(s);
    rxd_in = 1'b0; idle(4 * div_of(s));
    rxd_in = 1'b1; idle(12 * 16 * div_of(s));
    chk("R9 short low pulse rejected", n_strobe - n0, 0);
  endtask

  task automatic t_loop(input int s, input logic [7:0] b);
    int bl = 16 * div_of(s);
    int n0;
    int hi_bad = 0;
    rate_sel = 2'(s); loop_en = 1'b1; rxd_in = 1'b0;
    n0 = n_strobe;
    idle(12 * bl);
    chk("R7 low rxd_in ignored in loopback", n_strobe - n0, 0);
    chk("R2 idle high in loopback", int'(txd_out), 1);
    tx_byte = b; tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
    idle(4 * bl);
    chk("R5 busy before extra request", int'(tx_rdy), 0);
    tx_byte = ~b; tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0; tx_byte = 8'h00;
    idle(8 * bl);
    chk("R7 byte looped back", int'(got_byte), int'(b));
    chk("R7 one strobe in loopback", n_strobe - n0, 1);
    for (int k = 0; k < 12 * bl; k++) begin
      if (txd_out !== 1'b1) hi_bad++;
      @(negedge clk);
    end
    chk("R5 no frame from busy request", hi_bad, 0);
    chk("R5 still one strobe", n_strobe - n0, 1);
    chk("R5 ready after frame", int'(tx_rdy), 1);
    rxd_in = 1'b1; idle(4);
    loop_en = 1'b0; idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_frame(0, 8'hA5);
    t_tx_frame(1, 8'h3C);
    t_tx_frame(2, 8'h81);
    t_tx_frame(3, 8'h5B);
    t_rx_ext(0, 8'hC6);
    t_rx_ext(3, 8'h01);
    t_rx_ext(1, 8'hFE);
    t_frame_err(2);
    t_glitch(1);
    t_loop(2, 8'hD2);
    t_loop(0, 8'h47);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule